// File: doc/BRIEF.md
# Panel Register Init Sequencer

This block brings up an LCD panel controller over a write-only serial link after reset. On a start request it reads a fixed table of 24 register address/value pairs held on chip and programs them in table order. Each pair goes out as two frames of 24 bits, each framed by its own chip-select pulse. The address frame comes first and the data frame second. When the last data frame and its chip-select gap are finished, the sequence is over and the panel enable line can be controlled.

The serial clock comes from the system clock through a parameterised half-period divider and idles low. MOSI is updated only while SCLK is low, and the panel samples it on the rising edge. Chip select is held high for a parameterised number of SCLK periods between frames. The FSM has seven states:

- S_IDLE waits for start.
- S_IDX_GO launches the address frame, then S_IDX_WAIT waits for it to finish.
- S_VAL_GO launches the data frame, then S_VAL_WAIT waits for it to finish.
- From S_VAL_WAIT the FSM moves to S_IDX_GO for the next entry, or to S_DONE after the last entry.
- S_DONE lasts one cycle and then moves to S_READY.
- In S_READY, enable and disable requests drive the panel enable line, and a new start runs the sequence again.

Top module: `panel_init_seq`

## Requirements
- R1: Each address frame carries 24 bits, MSB first, during a single CS_n low window: 0x70, then 0x00, then a byte with bit 7 zero and the register address in bits 6..0.
- R2: Each data frame carries 24 bits, MSB first, during a single CS_n low window: 0x72, then the value's bits 15..8, then bits 7..0.
- R3: A full run sends 48 frames, alternating address and data. The 24 pairs go out in this order: 01=6300, 02=0200, 03=0177, 04=04C7, 05=FFC0, 06=E806, 0A=4008, 0B=0000, 0D=0030, 0E=2800, 0F=0000, 16=9F80, 17=0A0F, 1E=00C1, 30=0300, 31=0007, 32=0000, 33=0000, 34=0707, 35=0004, 36=0302, 37=0202, 3A=0A0D, 3B=0806.
- R4: SCLK is low whenever a frame starts. MOSI never changes while SCLK is high inside a frame.
- R5: Between two frames, CS_n stays high for at least 2*GAP_SCLK*HALF_DIV system clock cycles, which is GAP_SCLK SCLK periods.
- R6: busy goes high in the cycle after an accepted start and stays high until the final data frame's gap ends. A start request while busy is ignored.
- R7: done is high for exactly one cycle, the cycle right after busy falls. busy is low while done is high.
- R8: pnl_en is low from reset and for the whole of every init run. An enable request during a run is ignored. A start request issued from the ready state drops pnl_en at the same edge at which busy rises.
- R9: After init, en_req sets pnl_en on the next clock edge and dis_req clears it. If both requests arrive in the same cycle, dis_req wins.
- R10: During and after reset, with no frame in progress, CS_n is high, SCLK is low, and busy, done and pnl_en are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to run the init table |
| en_req | input | 1 | Request to raise the panel enable |
| dis_req | input | 1 | Request to drop the panel enable |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the panel |
| cs_n | output | 1 | Active-low chip select |
| pnl_en | output | 1 | Panel enable line |
| busy | output | 1 | Init sequence in progress |
| done | output | 1 | One-cycle pulse at the end of init |

## Verification
busy, pnl_en and done each change one clock edge after the cause. busy and pnl_en respond one edge after a request, and done follows one edge after the last frame gap ends. The bench therefore drives requests on the falling clock edge and samples these outputs on the next falling edge. Serial frames are captured on each rising SCLK edge while CS_n is low and are closed when CS_n rises. The chip-select gap is measured in system cycles. Every frame is then compared, after the run has completed, against a vector table of expected address/value pairs walked by one loop.

// File: rtl/panel_init_pkg.sv
package panel_init_pkg;

    localparam int TBL_N  = 24;
    localparam int PTR_W  = $clog2(TBL_N);
    localparam int FRM_W  = 24;

    typedef struct packed {
        logic [6:0]  addr;
        logic [15:0] data;
    } reg_pair_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_IDX_GO,
        S_IDX_WAIT,
        S_VAL_GO,
        S_VAL_WAIT,
        S_DONE,
        S_READY
    } seq_state_t;

    typedef enum logic [1:0] {
        T_IDLE,
        T_SHIFT,
        T_GAP
    } tx_state_t;

    function automatic reg_pair_t pair_at(input logic [PTR_W-1:0] i);
        reg_pair_t p;
        unique case (i)
            5'd0:    p = '{7'h01, 16'h6300};
            5'd1:    p = '{7'h02, 16'h0200};
            5'd2:    p = '{7'h03, 16'h0177};
            5'd3:    p = '{7'h04, 16'h04C7};
            5'd4:    p = '{7'h05, 16'hFFC0};
            5'd5:    p = '{7'h06, 16'hE806};
            5'd6:    p = '{7'h0A, 16'h4008};
            5'd7:    p = '{7'h0B, 16'h0000};
            5'd8:    p = '{7'h0D, 16'h0030};
            5'd9:    p = '{7'h0E, 16'h2800};
            5'd10:   p = '{7'h0F, 16'h0000};
            5'd11:   p = '{7'h16, 16'h9F80};
            5'd12:   p = '{7'h17, 16'h0A0F};
            5'd13:   p = '{7'h1E, 16'h00C1};
            5'd14:   p = '{7'h30, 16'h0300};
            5'd15:   p = '{7'h31, 16'h0007};
            5'd16:   p = '{7'h32, 16'h0000};
            5'd17:   p = '{7'h33, 16'h0000};
            5'd18:   p = '{7'h34, 16'h0707};
            5'd19:   p = '{7'h35, 16'h0004};
            5'd20:   p = '{7'h36, 16'h0302};
            5'd21:   p = '{7'h37, 16'h0202};
            5'd22:   p = '{7'h3A, 16'h0A0D};
            5'd23:   p = '{7'h3B, 16'h0806};
            default: p = '{7'h00, 16'h0000};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/spi_frame_tx.sv
module spi_frame_tx
    import panel_init_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int GAP_SCLK = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [FRM_W-1:0] frame,
    output logic             sclk,
    output logic             mosi,
    output logic             cs_n,
    output logic             fin
);

    localparam int GAP_CYC = 2 * HALF_DIV * GAP_SCLK;
    localparam int DIV_W   = $clog2(HALF_DIV + 1);
    localparam int BIT_W   = $clog2(FRM_W);
    localparam int GAP_W   = $clog2(GAP_CYC + 1);

    tx_state_t        st;
    logic [FRM_W-1:0] sreg;
    logic [DIV_W-1:0] div;
    logic [BIT_W-1:0] bitc;
    logic [GAP_W-1:0] gcnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= T_IDLE;
            sreg <= '0;
            div  <= '0;
            bitc <= '0;
            gcnt <= '0;
            sclk <= 1'b0;
            cs_n <= 1'b1;
        end else begin
            unique case (st)
                T_IDLE: begin
                    if (go) begin
                        sreg <= frame;
                        cs_n <= 1'b0;
                        div  <= '0;
                        bitc <= '0;
                        st   <= T_SHIFT;
                    end
                end
                T_SHIFT: begin
                    if (div == DIV_W'(HALF_DIV - 1)) begin
                        div  <= '0;
                        sclk <= ~sclk;
                        if (sclk) begin
                            if (bitc == BIT_W'(FRM_W - 1)) begin
                                cs_n <= 1'b1;
                                gcnt <= '0;
                                st   <= T_GAP;
                            end else begin
                                bitc <= bitc + 1'b1;
                                sreg <= {sreg[FRM_W-2:0], 1'b0};
                            end
                        end
                    end else begin
                        div <= div + 1'b1;
                    end
                end
                T_GAP: begin
                    if (gcnt == GAP_W'(GAP_CYC - 1)) st <= T_IDLE;
                    else                             gcnt <= gcnt + 1'b1;
                end
                default: st <= T_IDLE;
            endcase
        end
    end

    always_comb begin
        mosi = sreg[FRM_W-1];
        fin  = (st == T_GAP) && (gcnt == GAP_W'(GAP_CYC - 1));
    end

    // Checker state: cycles CS_n has been high, saturating
    logic [GAP_W-1:0] hi_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)    hi_cnt <= GAP_W'(GAP_CYC);
        else if (!cs_n) hi_cnt <= '0;
        else if (hi_cnt != GAP_W'(GAP_CYC)) hi_cnt <= hi_cnt + 1'b1;
    end

    // R4: MOSI held while SCLK high inside a frame
    p_mosi_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && sclk && $past(sclk) && !$past(cs_n)) |-> $stable(mosi));

    // R4: frame begins with SCLK low
    p_start_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> !sclk);

    // R5: CS_n high long enough before a new frame
    p_cs_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == T_IDLE && go) |-> (hi_cnt >= GAP_W'(GAP_CYC)));

endmodule

// File: rtl/panel_init_seq.sv
module panel_init_seq
    import panel_init_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int GAP_SCLK = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic en_req,
    input  logic dis_req,
    output logic sclk,
    output logic mosi,
    output logic cs_n,
    output logic pnl_en,
    output logic busy,
    output logic done
);

    localparam logic [7:0] LEAD_ADDR = 8'h70;
    localparam logic [7:0] LEAD_DATA = 8'h72;

    seq_state_t       state, nxt;
    logic [PTR_W-1:0] ptr;
    logic             tx_go, tx_fin, last;
    logic [FRM_W-1:0] tx_frame;
    reg_pair_t        cur;

    assign cur  = pair_at(ptr);
    assign last = (ptr == PTR_W'(TBL_N - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:     if (start) nxt = S_IDX_GO;
            S_IDX_GO:   nxt = S_IDX_WAIT;
            S_IDX_WAIT: if (tx_fin) nxt = S_VAL_GO;
            S_VAL_GO:   nxt = S_VAL_WAIT;
            S_VAL_WAIT: if (tx_fin) nxt = last ? S_DONE : S_IDX_GO;
            S_DONE:     nxt = S_READY;
            S_READY:    if (start) nxt = S_IDX_GO;
            default:    nxt = S_IDLE;
        endcase
    end

    // table pointer and panel enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr    <= '0;
            pnl_en <= 1'b0;
        end else begin
            if ((state == S_IDLE || state == S_READY) && start)
                ptr <= '0;
            else if (state == S_VAL_WAIT && tx_fin && !last)
                ptr <= ptr + 1'b1;

            if (state != S_READY || start) pnl_en <= 1'b0;
            else if (dis_req)              pnl_en <= 1'b0;
            else if (en_req)               pnl_en <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        tx_go    = (state == S_IDX_GO) || (state == S_VAL_GO);
        tx_frame = (state == S_VAL_GO)
                 ? {LEAD_DATA, cur.data}
                 : {LEAD_ADDR, 8'h00, 1'b0, cur.addr};
        busy     = (state == S_IDX_GO) || (state == S_IDX_WAIT) ||
                   (state == S_VAL_GO) || (state == S_VAL_WAIT);
        done     = (state == S_DONE);
    end

    spi_frame_tx #(
        .HALF_DIV (HALF_DIV),
        .GAP_SCLK (GAP_SCLK)
    ) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (tx_go),
        .frame (tx_frame),
        .sclk  (sclk),
        .mosi  (mosi),
        .cs_n  (cs_n),
        .fin   (tx_fin)
    );

    // R8: panel enable low while init runs
    p_en_low_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !pnl_en);

    // R7: done lasts one cycle and never overlaps busy
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6: start during a run does not restart the table
    p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && ptr != '0) |=> (ptr != '0));

    // R9: enable request in ready state takes effect
    p_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_READY && en_req && !dis_req && !start) |=> pnl_en);
    p_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_READY && dis_req) |=> !pnl_en);

endmodule

// File: tb/panel_init_seq_bench.sv
module panel_init_seq_bench;

    localparam int HALF_DIV = 2;
    localparam int GAP_SCLK = 2;
    localparam int MIN_GAP  = 2 * HALF_DIV * GAP_SCLK;
    localparam int NPAIR    = 24;

    // expected address/value vectors
    localparam logic [22:0] VEC [NPAIR] = '{
        {7'h01,16'h6300}, {7'h02,16'h0200}, {7'h03,16'h0177}, {7'h04,16'h04C7},
        {7'h05,16'hFFC0}, {7'h06,16'hE806}, {7'h0A,16'h4008}, {7'h0B,16'h0000},
        {7'h0D,16'h0030}, {7'h0E,16'h2800}, {7'h0F,16'h0000}, {7'h16,16'h9F80},
        {7'h17,16'h0A0F}, {7'h1E,16'h00C1}, {7'h30,16'h0300}, {7'h31,16'h0007},
        {7'h32,16'h0000}, {7'h33,16'h0000}, {7'h34,16'h0707}, {7'h35,16'h0004},
        {7'h36,16'h0302}, {7'h37,16'h0202}, {7'h3A,16'h0A0D}, {7'h3B,16'h0806}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, en_req = 1'b0, dis_req = 1'b0;
    logic sclk, mosi, cs_n, pnl_en, busy, done;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    panel_init_seq #(.HALF_DIV(HALF_DIV), .GAP_SCLK(GAP_SCLK)) u_panel_init_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .en_req(en_req), .dis_req(dis_req),
        .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .pnl_en(pnl_en),
        .busy(busy), .done(done)
    );

    // serial capture
    logic [23:0] frm_data [0:127];
    int          frm_bits [0:127];
    int          nfr = 0;
    logic [23:0] shreg = '0;
    int          nbits = 0;

    always @(posedge sclk) if (!cs_n) begin
        shreg = {shreg[22:0], mosi};
        nbits = nbits + 1;
    end

    always @(posedge cs_n) if (rst_n && nfr < 128) begin
        frm_data[nfr] = shreg;
        frm_bits[nfr] = nbits;
        nfr = nfr + 1;
    end

    always @(negedge cs_n) if (rst_n) nbits = 0;

    // gap, mode and done monitors
    int hi_run   = 0;
    int min_gap  = 1 << 30;
    int mode_err = 0;
    int start_hi = 0;
    int done_cnt = 0;
    logic prev_sclk = 1'b0, prev_mosi = 1'b0, prev_cs = 1'b1;

    always @(posedge clk) if (rst_n) begin
        if (prev_cs && !cs_n && nfr > 0 && hi_run < min_gap) min_gap = hi_run;
        if (prev_cs && !cs_n && sclk) start_hi = start_hi + 1;
        if (cs_n) hi_run = hi_run + 1; else hi_run = 0;
        if (!cs_n && sclk && prev_sclk && !prev_cs && mosi !== prev_mosi)
            mode_err = mode_err + 1;
        if (done) done_cnt = done_cnt + 1;
        prev_sclk = sclk;
        prev_mosi = mosi;
        prev_cs   = cs_n;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic pulse(input int which);
        if (which == 0) start = 1'b1;
        if (which == 1) en_req = 1'b1;
        if (which == 2) dis_req = 1'b1;
        if (which == 3) begin en_req = 1'b1; dis_req = 1'b1; end
        @(negedge clk);
        start = 1'b0; en_req = 1'b0; dis_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad = bad + 1;
        total = total + 1;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int waited;
        cyc(5);
        // R10: reset state
        chk("R10 cs_n", {31'd0, cs_n}, 1);
        chk("R10 sclk", {31'd0, sclk}, 0);
        chk("R10 busy", {31'd0, busy}, 0);
        chk("R10 pnl_en", {31'd0, pnl_en}, 0);
        rst_n = 1'b1;
        cyc(2);
        // R8: enable before init ignored
        pulse(1);
        chk("R8 en before init", {31'd0, pnl_en}, 0);
        // R6: busy after start
        pulse(0);
        chk("R6 busy rise", {31'd0, busy}, 1);
        chk("R8 en low at start", {31'd0, pnl_en}, 0);
        cyc(300);
        // R8: enable during run ignored; R6: start during run ignored
        pulse(1);
        chk("R8 en during run", {31'd0, pnl_en}, 0);
        pulse(0);
        chk("R6 still busy", {31'd0, busy}, 1);
        waited = 0;
        while (!done && waited < 20000) begin
            chk("R6 busy held", {31'd0, busy}, 1);
            @(negedge clk);
            waited++;
        end
        chk("R7 done seen", {31'd0, done}, 1);
        chk("R7 busy low at done", {31'd0, busy}, 0);
        chk("R6 frames at done", nfr, 2 * NPAIR);
        cyc(1);
        chk("R7 done one cycle", {31'd0, done}, 0);
        cyc(200);
        chk("R6 no extra frames", nfr, 2 * NPAIR);
        chk("R7 done count", done_cnt, 1);
        chk("R10 cs_n idle", {31'd0, cs_n}, 1);
        chk("R10 sclk idle", {31'd0, sclk}, 0);
        // R1 R2 R3: walk the vector table
        for (int i = 0; i < NPAIR; i++) begin
            chk("R1 addr frame", frm_data[2*i], {8'h70, 8'h00, 1'b0, VEC[i][22:16]});
            chk("R1 addr bits", frm_bits[2*i], 24);
            chk("R2 data frame", frm_data[2*i+1], {8'h72, VEC[i][15:0]});
            chk("R3 data bits", frm_bits[2*i+1], 24);
        end
        chk("R4 mosi stable", mode_err, 0);
        chk("R4 sclk low at frame start", start_hi, 0);
        chk("R5 min gap ok", {31'd0, (min_gap >= MIN_GAP)}, 1);
        // R9: enable control
        chk("R9 en low after init", {31'd0, pnl_en}, 0);
        pulse(1);
        chk("R9 enable", {31'd0, pnl_en}, 1);
        pulse(2);
        chk("R9 disable", {31'd0, pnl_en}, 0);
        pulse(1);
        chk("R9 re-enable", {31'd0, pnl_en}, 1);
        pulse(3);
        chk("R9 disable wins", {31'd0, pnl_en}, 0);
        pulse(1);
        // R8: restart from ready drops enable
        pulse(0);
        chk("R8 restart drops en", {31'd0, pnl_en}, 0);
        chk("R8 restart busy", {31'd0, busy}, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule